// File: doc/BRIEF.md
# Queue Doorbell Register Decoder

This block sits behind the register window of a storage controller and handles every write that lands in the doorbell region. That region starts at offset 0x1000. Four-byte slots alternate between two kinds of pointer register. The even slot of each eight-byte pair holds the tail of a submission queue, and the odd slot holds the head of a completion queue. For each write, the block validates the address and the queue, checks the new value against the size of that queue, and stores it. It then raises one-cycle request pulses for the engines that fetch commands and post completions.

The queue-creation logic supplies, for every queue id:
- a created flag,
- the ring size in entries,
- the current completion-queue tail,
- the completion queue that each submission queue reports to.

The block keeps every stored pointer at zero while its queue is not created. A completion head write can free space in a ring that was full. When that happens, every created submission queue bound to that ring is woken. If entries remain unconsumed after a head write, the interrupt of that completion queue is raised again.

Top module: `dbl_doorbell_decoder`

## Requirements
- R1: A write with an address below 0x1000, or with either of address bits [1:0] set, changes no pointer and raises no pulse.
- R2: For an accepted write, let off = address − 0x1000. Bit 2 of off selects the register: 0 selects a submission tail and 1 selects a completion head. The queue id is off >> 3.
- R3: A write whose queue id is NQ or greater, or names a queue whose created flag is low, changes no pointer and raises no pulse.
- R4: Only data bits [15:0] form the new pointer value. A value greater than or equal to the queue's size is ignored.
- R5: An accepted submission-tail write stores the value. In the cycle after the write, sq_kick has exactly that queue's bit high for one cycle.
- R6: An accepted completion-head write stores the value, and the new head is visible on cq_head in the cycle after the write.
- R7: A completion queue counts as full before a head write when (tail + 1) mod size equals the old head. In that case an accepted head write raises that queue's cq_wake bit in the next cycle. In the same cycle it raises the sq_kick bit of every created submission queue whose mapping names that completion queue.
- R8: If the completion tail differs from the newly written head, an accepted head write raises that queue's cq_irq bit in the next cycle.
- R9: During and after reset, all pointers read zero and all pulse vectors are low.
- R10: Every pulse lasts one cycle, and no pulse rises without a doorbell write in the previous cycle.
- R11: The stored pointer of a queue whose created flag is low reads zero from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data; bits [15:0] are used |
| sq_created | input | NQ | Created flag per submission queue |
| cq_created | input | NQ | Created flag per completion queue |
| sq_size | input | NQ×PTR_W | Ring size in entries per submission queue |
| cq_size | input | NQ×PTR_W | Ring size in entries per completion queue |
| sq_map | input | NQ×QID_W | Completion queue id that each submission queue reports to |
| cq_tail_in | input | NQ×PTR_W | Current tail of each completion queue |
| sq_tail | output | NQ×PTR_W | Stored submission tails |
| cq_head | output | NQ×PTR_W | Stored completion heads |
| sq_kick | output | NQ | One-cycle fetch request per submission queue |
| cq_wake | output | NQ | One-cycle posting resume per completion queue |
| cq_irq | output | NQ | One-cycle interrupt re-raise per completion queue |

## Verification
Every result of a write is due one clock edge after the edge that samples the write. This includes the stored pointer and the kick, wake and interrupt pulses. The bench drives each write on a falling edge and lets the next rising edge capture it. It samples all outputs on the following falling edge, then samples once more a cycle later to confirm the pulses have fallen. Expected values come from a bench model of the pointers. The full condition is evaluated on the model's head before the write.

// File: rtl/dbd_pkg.sv
package dbd_pkg;
  typedef enum logic {
    DB_SQ_TAIL = 1'b0,
    DB_CQ_HEAD = 1'b1
  } db_kind_e;

  typedef struct packed {
    logic     hit;
    db_kind_e kind;
  } db_sel_t;
endpackage

// File: rtl/dbd_addr_dec.sv
module dbd_addr_dec #(
  parameter int ADDR_W  = 16,
  parameter int NQ      = 64,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  output dbd_pkg::db_sel_t    sel,
  output logic [QID_W-1:0]    qid
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] idx;
  logic              above, aligned, in_range;

  always_comb begin
    off      = wr_addr - ADDR_W'(DB_BASE);
    idx      = off >> 3;
    above    = (wr_addr >= ADDR_W'(DB_BASE));
    aligned  = (wr_addr[1:0] == 2'b00);
    in_range = (idx < ADDR_W'(NQ));
    sel.hit  = wr_en & above & aligned & in_range;
    sel.kind = off[2] ? dbd_pkg::DB_CQ_HEAD : dbd_pkg::DB_SQ_TAIL;
    qid      = idx[QID_W-1:0];
  end

  // R1 guard: a decoded hit never comes from a misaligned address
  always_comb begin
    if (sel.hit) begin
      a_hit_aligned_r1: assert (wr_addr[1:0] == 2'b00);
    end
  end
endmodule

// File: rtl/dbd_sq_bank.sv
module dbd_sq_bank #(
  parameter int NQ     = 64,
  parameter int PTR_W  = 16,
  localparam int QID_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_vld,
  input  logic [QID_W-1:0]             wr_qid,
  input  logic [PTR_W-1:0]             wr_val,
  input  logic [NQ-1:0]                created,
  input  logic [NQ-1:0][PTR_W-1:0]     size,
  input  logic [NQ-1:0][QID_W-1:0]     map,
  input  logic                         wake_vld,
  input  logic [QID_W-1:0]             wake_cqid,
  output logic [NQ-1:0][PTR_W-1:0]     tail,
  output logic [NQ-1:0]                kick
);
  logic [NQ-1:0]             accept, tail_en, kick_d;
  logic [NQ-1:0][PTR_W-1:0]  tail_d;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    always_comb begin
      accept[q] = wr_vld && (wr_qid == QID_W'(q)) && created[q] && (wr_val < size[q]);
      tail_en[q] = accept[q] | ~created[q];
      tail_d[q]  = created[q] ? wr_val : '0;
      kick_d[q]  = accept[q] | (wake_vld & created[q] & (map[q] == wake_cqid));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tail[q] <= '0;
      end else if (tail_en[q]) begin
        tail[q] <= tail_d[q];
      end
    end

    p_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
      accept[q] |=> (tail[q] == $past(wr_val)));
    p_deleted_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !created[q] |=> (tail[q] == '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kick <= '0;
    end else begin
      kick <= kick_d;
    end
  end

  p_kick_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|kick) |-> $past(wr_vld | wake_vld));
endmodule

// File: rtl/dbd_cq_bank.sv
module dbd_cq_bank #(
  parameter int NQ     = 64,
  parameter int PTR_W  = 16,
  localparam int QID_W = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_vld,
  input  logic [QID_W-1:0]             wr_qid,
  input  logic [PTR_W-1:0]             wr_val,
  input  logic [NQ-1:0]                created,
  input  logic [NQ-1:0][PTR_W-1:0]     size,
  input  logic [NQ-1:0][PTR_W-1:0]     tail_in,
  output logic [NQ-1:0][PTR_W-1:0]     head,
  output logic [NQ-1:0]                wake,
  output logic [NQ-1:0]                irq,
  output logic                         relief_vld,
  output logic [QID_W-1:0]             relief_qid
);
  logic [NQ-1:0]             accept, head_en, full, wake_d, irq_d;
  logic [NQ-1:0][PTR_W-1:0]  head_d;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    logic [PTR_W:0]   nxt;
    logic [PTR_W-1:0] nxt_wrap;

    always_comb begin
      nxt        = {1'b0, tail_in[q]} + 1'b1;
      nxt_wrap   = (nxt >= {1'b0, size[q]}) ? '0 : nxt[PTR_W-1:0];
      full[q]    = (nxt_wrap == head[q]);
      accept[q]  = wr_vld && (wr_qid == QID_W'(q)) && created[q] && (wr_val < size[q]);
      head_en[q] = accept[q] | ~created[q];
      head_d[q]  = created[q] ? wr_val : '0;
      wake_d[q]  = accept[q] & full[q];
      irq_d[q]   = accept[q] & (tail_in[q] != wr_val);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        head[q] <= '0;
      end else if (head_en[q]) begin
        head[q] <= head_d[q];
      end
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (created[q] && !accept[q]) |=> $stable(head[q]));
    p_irq_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq[q] |-> (head[q] != $past(tail_in[q])));
    p_wake_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wake[q] |-> $past(full[q]));
  end

  always_comb begin
    relief_vld = |wake_d;
    relief_qid = wr_qid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake <= '0;
      irq  <= '0;
    end else begin
      wake <= wake_d;
      irq  <= irq_d;
    end
  end

  p_one_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake));
endmodule

// File: rtl/dbl_doorbell_decoder.sv
module dbl_doorbell_decoder #(
  parameter int ADDR_W  = 16,
  parameter int NQ      = 64,
  parameter int PTR_W   = 16,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [31:0]                wr_data,
  input  logic [NQ-1:0]              sq_created,
  input  logic [NQ-1:0]              cq_created,
  input  logic [NQ-1:0][PTR_W-1:0]   sq_size,
  input  logic [NQ-1:0][PTR_W-1:0]   cq_size,
  input  logic [NQ-1:0][QID_W-1:0]   sq_map,
  input  logic [NQ-1:0][PTR_W-1:0]   cq_tail_in,
  output logic [NQ-1:0][PTR_W-1:0]   sq_tail,
  output logic [NQ-1:0][PTR_W-1:0]   cq_head,
  output logic [NQ-1:0]              sq_kick,
  output logic [NQ-1:0]              cq_wake,
  output logic [NQ-1:0]              cq_irq
);
  dbd_pkg::db_sel_t  sel;
  logic [QID_W-1:0]  qid;
  logic [PTR_W-1:0]  val;
  logic              sq_wr, cq_wr, relief_vld;
  logic [QID_W-1:0]  relief_qid;

  dbd_addr_dec #(.ADDR_W(ADDR_W), .NQ(NQ), .DB_BASE(DB_BASE)) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .sel(sel), .qid(qid)
  );

  always_comb begin
    val   = wr_data[PTR_W-1:0];
    sq_wr = sel.hit & (sel.kind == dbd_pkg::DB_SQ_TAIL);
    cq_wr = sel.hit & (sel.kind == dbd_pkg::DB_CQ_HEAD);
  end

  dbd_cq_bank #(.NQ(NQ), .PTR_W(PTR_W)) u_cq (
    .clk(clk), .rst_n(rst_n), .wr_vld(cq_wr), .wr_qid(qid), .wr_val(val),
    .created(cq_created), .size(cq_size), .tail_in(cq_tail_in),
    .head(cq_head), .wake(cq_wake), .irq(cq_irq),
    .relief_vld(relief_vld), .relief_qid(relief_qid)
  );

  dbd_sq_bank #(.NQ(NQ), .PTR_W(PTR_W)) u_sq (
    .clk(clk), .rst_n(rst_n), .wr_vld(sq_wr), .wr_qid(qid), .wr_val(val),
    .created(sq_created), .size(sq_size), .map(sq_map),
    .wake_vld(relief_vld), .wake_cqid(relief_qid),
    .tail(sq_tail), .kick(sq_kick)
  );

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr < ADDR_W'(DB_BASE))) |=> (sq_kick == '0 && cq_wake == '0 && cq_irq == '0));
  p_kick_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_wr && sq_created[qid] && val < sq_size[qid]) |=> $onehot(sq_kick));
endmodule

// File: tb/dbl_doorbell_decoder_tb.sv
module dbl_doorbell_decoder_tb;
  localparam int NQ = 64, PTR_W = 16, QID_W = 6, ADDR_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [31:0] wr_data;
  logic [NQ-1:0] sq_created, cq_created;
  logic [NQ-1:0][PTR_W-1:0] sq_size, cq_size, cq_tail_in, sq_tail, cq_head;
  logic [NQ-1:0][QID_W-1:0] sq_map;
  logic [NQ-1:0] sq_kick, cq_wake, cq_irq;

  logic [NQ-1:0][PTR_W-1:0] m_tail, m_head;
  logic [NQ-1:0] e_kick, e_wake, e_irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dbl_doorbell_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .sq_created(sq_created), .cq_created(cq_created), .sq_size(sq_size),
    .cq_size(cq_size), .sq_map(sq_map), .cq_tail_in(cq_tail_in),
    .sq_tail(sq_tail), .cq_head(cq_head), .sq_kick(sq_kick),
    .cq_wake(cq_wake), .cq_irq(cq_irq)
  );

  function automatic logic [ADDR_W-1:0] sq_addr(int q);
    return ADDR_W'('h1000 + q * 8);
  endfunction
  function automatic logic [ADDR_W-1:0] cq_addr(int q);
    return ADDR_W'('h1004 + q * 8);
  endfunction
  function automatic bit ring_full(int t, int h, int s);
    return ((t + 1) % s) == h;
  endfunction

  task automatic chk_vec(string tag, string what, logic [1023:0] act, logic [1023:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk_vec(tag, "sq_tail", 1024'(sq_tail), 1024'(m_tail));
    chk_vec(tag, "cq_head", 1024'(cq_head), 1024'(m_head));
    chk_vec(tag, "sq_kick", 1024'(sq_kick), 1024'(e_kick));
    chk_vec(tag, "cq_wake", 1024'(cq_wake), 1024'(e_wake));
    chk_vec(tag, "cq_irq",  1024'(cq_irq),  1024'(e_irq));
  endtask

  // model of one write; sets the expected pulses
  task automatic model(logic [ADDR_W-1:0] a, logic [31:0] d);
    int off, q;
    int v;
    e_kick = '0; e_wake = '0; e_irq = '0;
    if (a < 16'h1000 || a[1:0] != 2'b00) return;
    off = int'(a) - 'h1000;
    q = off >> 3;
    v = int'(d[15:0]);
    if (q >= NQ) return;
    if ((off & 4) == 0) begin
      if (!sq_created[q] || v >= int'(sq_size[q])) return;
      m_tail[q] = PTR_W'(v);
      e_kick[q] = 1'b1;
    end else begin
      if (!cq_created[q] || v >= int'(cq_size[q])) return;
      if (ring_full(int'(cq_tail_in[q]), int'(m_head[q]), int'(cq_size[q]))) begin
        e_wake[q] = 1'b1;
        for (int s = 0; s < NQ; s++)
          if (sq_created[s] && int'(sq_map[s]) == q) e_kick[s] = 1'b1;
      end
      if (int'(cq_tail_in[q]) != v) e_irq[q] = 1'b1;
      m_head[q] = PTR_W'(v);
    end
  endtask

  task automatic do_write(string tag, logic [ADDR_W-1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    model(a, d);
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag);
    e_kick = '0; e_wake = '0; e_irq = '0;
    @(negedge clk);
    check_all({tag, "_R10"});
  endtask

  initial begin
    #1000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    wr_en = 0; wr_addr = '0; wr_data = '0;
    sq_created = '0; cq_created = '0; sq_size = '0; cq_size = '0;
    sq_map = '0; cq_tail_in = '0;
    for (int q = 0; q < 8; q++) begin
      sq_size[q] = PTR_W'(4 + q % 5);
      cq_size[q] = PTR_W'(4 + (q * 3) % 5);
      sq_map[q]  = QID_W'(q % 4);
      sq_created[q] = (q != 7);
      cq_created[q] = (q < 6);
    end
    m_tail = '0; m_head = '0; e_kick = '0; e_wake = '0; e_irq = '0;
    repeat (3) @(negedge clk);
    check_all("R9");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9");

    // R5 / R2 plain tail write
    do_write("R5", sq_addr(2), 32'd3);
    // R4 upper data bits ignored
    do_write("R4", sq_addr(3), 32'hABCD_0002);
    // R4 value equal to size ignored
    do_write("R4", sq_addr(0), 32'd4);
    // R1 below base and misaligned
    do_write("R1", 16'h0ff8, 32'd1);
    do_write("R1", sq_addr(1) + 16'd2, 32'd1);
    // R3 queue id out of range and not created
    do_write("R3", sq_addr(70), 32'd1);
    do_write("R3", cq_addr(7), 32'd1);
    do_write("R3", sq_addr(7), 32'd1);
    // R7 directed full: cq1 size 7, tail 6, head 0 -> full
    cq_tail_in[1] = 16'd6;
    do_write("R7", cq_addr(1), 32'd2);
    // R8 head equal to tail: no interrupt
    cq_tail_in[2] = 16'd1;
    do_write("R8", cq_addr(2), 32'd1);
    do_write("R6", cq_addr(2), 32'd0);
    // R11 deletion clears pointer
    @(negedge clk);
    sq_created[2] = 1'b0;
    m_tail[2] = '0;
    @(negedge clk);
    @(negedge clk);
    check_all("R11");
    sq_created[2] = 1'b1;

    for (int i = 0; i < 400; i++) begin
      int q, k;
      logic [ADDR_W-1:0] a;
      q = $urandom_range(0, 8);
      k = $urandom_range(0, 9);
      for (int c = 0; c < 6; c++)
        cq_tail_in[c] = PTR_W'($urandom_range(0, int'(cq_size[c]) - 1));
      if (k < 4)      a = sq_addr(q);
      else if (k < 8) a = cq_addr(q);
      else if (k == 8) a = cq_addr(q) + 16'd1;
      else             a = 16'h0100;
      do_write(k < 4 ? "R5" : (k < 8 ? "R7_R8" : "R1"), a, 32'($urandom_range(0, 9)));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule